// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block carries out the data movement of a single DMA channel once that channel has been started. A start pulse latches the channel configuration, the initial read address, the initial write address and the beat count. The sequencer then runs beats until the count is used up. Each beat issues a read request on a memory port and waits for its acknowledge. It then issues a write request that carries the read data, which can be byte-reversed on the way. After each completed write it updates both addresses and the remaining count. Each address can move up, move down or stay fixed. One of the two addresses can be confined to a power-of-two ring.

Beats either wait for a chosen peripheral request line or run back to back. When the count reaches zero the block pulses done. It also pulses an interrupt unless the quiet flag is set, and a chain trigger to a sibling channel unless that sibling is the channel itself. An error acknowledge or an abort ends the transfer early, and in that case no completion signals are raised.

The controller has four states. Idle waits for start. Pace finishes the transfer when the count is zero, and otherwise waits for the pacing request and then goes to Read. Read holds the read request until it is acknowledged, then goes to Write, or back to Idle on an error or a pending abort. Write holds the write request until it is acknowledged. It then goes back to Pace, or to Idle when the final beat is done, on an error, or on a pending abort.

Top module: `dma_chan_seq`

## Requirements
- R1: While idle, a start pulse latches all configuration, both addresses and the count, and busy reads 1 from the next cycle on. A start pulse while busy is ignored, as are configuration changes while busy.
- R2: Each beat is one read request followed by one write request, and the two requests are never high together. A request stays high, with a stable address and stable write data, until its acknowledge arrives.
- R3: The size code is 0 for a byte, 1 for a halfword and 2 for a word. It is driven on rd_size and wr_size and sets the address step to 1, 2 or 4 bytes.
- R4: After each completed write, an address whose increment enable is set rises by the step, or falls by the step when its reverse bit is also set. An address whose increment enable is clear stays fixed.
- R5: A ring exponent N that is not zero keeps the selected address inside its aligned 2^N-byte region: the upper bits stay fixed and the low N bits wrap. Select 0 applies the ring to the read address and 1 to the write address. N = 0 disables the ring.
- R6: Beat data sits in the low bytes of rd_data and wr_data, and the unused upper bytes of wr_data are zero. With swap set, the byte order within the beat is reversed: a halfword swaps its two bytes, a word its four, and a byte is unchanged.
- R7: A pacing select of 63 runs beats with no wait. Any other select value v lets a beat begin its read only while dreq[v] is high.
- R8: Exactly the latched count of beats is performed. A count of 0 performs no beats and completes at once.
- R9: Done pulses for one cycle in the cycle after the final write acknowledge, with busy already low. The interrupt pulses together with done unless the quiet flag is set.
- R10: Together with done, chain_trig pulses the one-hot bit named by the chain field. No bit pulses when that field equals the channel's own index.
- R11: An acknowledge with an error flag on the read or the write port sets the matching sticky error flag and ends the transfer with no done, no interrupt and no chain pulse. The next start clears both flags.
- R12: An abort while busy stops the transfer when the current request is acknowledged, or at once when no request is outstanding. Busy then drops, and done, the interrupt and the chain pulse stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken only while idle |
| abort | input | 1 | Stop the running transfer |
| cfg_size | input | 2 | Beat size code |
| cfg_rd_inc | input | 1 | Read address step enable |
| cfg_rd_rev | input | 1 | Read address steps downward |
| cfg_wr_inc | input | 1 | Write address step enable |
| cfg_wr_rev | input | 1 | Write address steps downward |
| cfg_ring_log | input | 4 | Ring size exponent, 0 disables the ring |
| cfg_ring_on_wr | input | 1 | Ring applies to write (1) or read (0) address |
| cfg_chain_to | input | $clog2(NUM_CH) | Channel to trigger on completion |
| cfg_pace_sel | input | 6 | Pacing request select, 63 means unpaced |
| cfg_quiet | input | 1 | Suppress the completion interrupt |
| cfg_swap | input | 1 | Reverse the bytes of each beat |
| init_rd_addr | input | AW | First read address |
| init_wr_addr | input | AW | First write address |
| init_count | input | CW | Number of beats |
| dreq | input | NUM_DREQ | Peripheral pacing requests |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Read address |
| rd_size | output | 2 | Read size code |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_err | input | 1 | Read error, qualified by rd_ack |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | AW | Write address |
| wr_size | output | 2 | Write size code |
| wr_data | output | 32 | Write data |
| wr_ack | input | 1 | Write acknowledge |
| wr_err | input | 1 | Write error, qualified by wr_ack |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Normal completion pulse |
| irq | output | 1 | Completion interrupt pulse |
| chain_trig | output | NUM_CH | One-hot trigger for the chained channel |
| rd_err_flag | output | 1 | Sticky read error |
| wr_err_flag | output | 1 | Sticky write error |

## Verification
Some properties are checked on every cycle. A read and a write request are never high together, and a waiting request keeps its address and data. A start taken while idle raises busy. Done never appears with busy still high. The interrupt and the chain pulse never appear without done, and the chain pulse is at most one-hot and never names the channel itself. The address arithmetic (steps, reversal and ring wrap), the byte swap, the effect of pacing, the beat count, the quiet flag and the early endings through errors and abort can only be shown by the bench's scenarios. There, every bus request is compared against an address and data model built from the requirements.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PACE,
        ST_READ,
        ST_WRITE
    } seq_state_e;

    localparam logic [5:0] PACE_FREE = 6'd63;

    typedef struct packed {
        logic [1:0] size;
        logic       rd_inc;
        logic       rd_rev;
        logic       wr_inc;
        logic       wr_rev;
        logic [3:0] ring_log;
        logic       ring_on_wr;
        logic [5:0] pace_sel;
        logic       quiet;
        logic       swap;
    } chan_cfg_t;

endpackage

// File: rtl/dma_addr_stepper.sv
module dma_addr_stepper #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr_i,
    input  logic          step_en,
    input  logic          reverse,
    input  logic [1:0]    size,
    input  logic          wrap_en,
    input  logic [3:0]    wrap_log,
    output logic [AW-1:0] addr_o
);
    logic [AW-1:0] stride;
    logic [AW-1:0] raw;
    logic [AW-1:0] mask;
    logic [AW-1:0] moved;

    always_comb begin
        unique case (size)
            2'd0:    stride = AW'(1);
            2'd1:    stride = AW'(2);
            default: stride = AW'(4);
        endcase
        raw    = reverse ? (addr_i - stride) : (addr_i + stride);
        mask   = (AW'(1) << wrap_log) - AW'(1);
        moved  = wrap_en ? ((addr_i & ~mask) | (raw & mask)) : raw;
        addr_o = step_en ? moved : addr_i;
    end
endmodule

// File: rtl/dma_beat_swap.sv
module dma_beat_swap #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] data_i,
    input  logic [1:0]    size,
    input  logic          swap_en,
    output logic [DW-1:0] data_o
);
    localparam int LANES = DW / 8;

    int nbytes;

    always_comb begin
        unique case (size)
            2'd0:    nbytes = 1;
            2'd1:    nbytes = 2;
            default: nbytes = 4;
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            if (g < nbytes) begin
                if (swap_en)
                    data_o[g*8 +: 8] = data_i[(nbytes-1-g)*8 +: 8];
                else
                    data_o[g*8 +: 8] = data_i[g*8 +: 8];
            end else begin
                data_o[g*8 +: 8] = 8'h00;
            end
        end
    end
endmodule

// File: rtl/dma_pace_gate.sv
module dma_pace_gate
    import dma_seq_pkg::*;
#(
    parameter int NUM_DREQ = 63
) (
    input  logic [NUM_DREQ-1:0] dreq,
    input  logic [5:0]          sel,
    output logic                go
);
    logic [63:0] padded;

    always_comb begin
        padded = 64'(dreq);
        go     = (sel == PACE_FREE) | padded[sel];
    end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int CH_IDX   = 0,
    parameter int NUM_CH   = 16,
    parameter int AW       = 32,
    parameter int CW       = 32,
    parameter int NUM_DREQ = 63
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      abort,
    input  logic [1:0]                cfg_size,
    input  logic                      cfg_rd_inc,
    input  logic                      cfg_rd_rev,
    input  logic                      cfg_wr_inc,
    input  logic                      cfg_wr_rev,
    input  logic [3:0]                cfg_ring_log,
    input  logic                      cfg_ring_on_wr,
    input  logic [$clog2(NUM_CH)-1:0] cfg_chain_to,
    input  logic [5:0]                cfg_pace_sel,
    input  logic                      cfg_quiet,
    input  logic                      cfg_swap,
    input  logic [AW-1:0]             init_rd_addr,
    input  logic [AW-1:0]             init_wr_addr,
    input  logic [CW-1:0]             init_count,
    input  logic [NUM_DREQ-1:0]       dreq,
    output logic                      rd_req,
    output logic [AW-1:0]             rd_addr,
    output logic [1:0]                rd_size,
    input  logic                      rd_ack,
    input  logic                      rd_err,
    input  logic [31:0]               rd_data,
    output logic                      wr_req,
    output logic [AW-1:0]             wr_addr,
    output logic [1:0]                wr_size,
    output logic [31:0]               wr_data,
    input  logic                      wr_ack,
    input  logic                      wr_err,
    output logic                      busy,
    output logic                      done,
    output logic                      irq,
    output logic [NUM_CH-1:0]         chain_trig,
    output logic                      rd_err_flag,
    output logic                      wr_err_flag
);
    localparam int CHW = $clog2(NUM_CH);
    localparam int DW  = 32;

    seq_state_e     state, nxt;
    chan_cfg_t      cfg_q;
    logic [CHW-1:0] chain_q;
    logic [AW-1:0]  rd_ptr, wr_ptr, rd_next, wr_next;
    logic [CW-1:0]  remain;
    logic [DW-1:0]  beat_data, swapped;
    logic           abort_pend;
    logic           stop_req;
    logic           pace_go;
    logic           finish;

    dma_addr_stepper #(.AW(AW)) u_rd_step (
        .addr_i   (rd_ptr),
        .step_en  (cfg_q.rd_inc),
        .reverse  (cfg_q.rd_rev),
        .size     (cfg_q.size),
        .wrap_en  ((cfg_q.ring_log != 4'd0) && !cfg_q.ring_on_wr),
        .wrap_log (cfg_q.ring_log),
        .addr_o   (rd_next)
    );

    dma_addr_stepper #(.AW(AW)) u_wr_step (
        .addr_i   (wr_ptr),
        .step_en  (cfg_q.wr_inc),
        .reverse  (cfg_q.wr_rev),
        .size     (cfg_q.size),
        .wrap_en  ((cfg_q.ring_log != 4'd0) && cfg_q.ring_on_wr),
        .wrap_log (cfg_q.ring_log),
        .addr_o   (wr_next)
    );

    dma_beat_swap #(.DW(DW)) u_swap (
        .data_i  (rd_data),
        .size    (cfg_q.size),
        .swap_en (cfg_q.swap),
        .data_o  (swapped)
    );

    dma_pace_gate #(.NUM_DREQ(NUM_DREQ)) u_pace (
        .dreq (dreq),
        .sel  (cfg_q.pace_sel),
        .go   (pace_go)
    );

    assign stop_req = abort | abort_pend;

    // Next-state logic
    always_comb begin
        nxt    = state;
        finish = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) nxt = ST_PACE;
            end
            ST_PACE: begin
                if (stop_req) begin
                    nxt = ST_IDLE;
                end else if (remain == '0) begin
                    nxt    = ST_IDLE;
                    finish = 1'b1;
                end else if (pace_go) begin
                    nxt = ST_READ;
                end
            end
            ST_READ: begin
                if (rd_ack) nxt = (rd_err || stop_req) ? ST_IDLE : ST_WRITE;
            end
            ST_WRITE: begin
                if (wr_ack) begin
                    if (wr_err || stop_req) begin
                        nxt = ST_IDLE;
                    end else if (remain == CW'(1)) begin
                        nxt    = ST_IDLE;
                        finish = 1'b1;
                    end else begin
                        nxt = ST_PACE;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q       <= '0;
            chain_q     <= '0;
            rd_ptr      <= '0;
            wr_ptr      <= '0;
            remain      <= '0;
            beat_data   <= '0;
            abort_pend  <= 1'b0;
            rd_err_flag <= 1'b0;
            wr_err_flag <= 1'b0;
            done        <= 1'b0;
            irq         <= 1'b0;
            chain_trig  <= '0;
        end else begin
            done       <= finish;
            irq        <= finish && !cfg_q.quiet;
            chain_trig <= (finish && (chain_q != CHW'(CH_IDX)))
                          ? (NUM_CH'(1) << chain_q) : '0;
            if (state == ST_IDLE) begin
                if (start) begin
                    cfg_q       <= '{size: cfg_size, rd_inc: cfg_rd_inc,
                                     rd_rev: cfg_rd_rev, wr_inc: cfg_wr_inc,
                                     wr_rev: cfg_wr_rev, ring_log: cfg_ring_log,
                                     ring_on_wr: cfg_ring_on_wr,
                                     pace_sel: cfg_pace_sel, quiet: cfg_quiet,
                                     swap: cfg_swap};
                    chain_q     <= cfg_chain_to;
                    rd_ptr      <= init_rd_addr;
                    wr_ptr      <= init_wr_addr;
                    remain      <= init_count;
                    abort_pend  <= 1'b0;
                    rd_err_flag <= 1'b0;
                    wr_err_flag <= 1'b0;
                end
            end else if (abort) begin
                abort_pend <= 1'b1;
            end
            if (state == ST_READ && rd_ack) begin
                beat_data <= swapped;
                if (rd_err) rd_err_flag <= 1'b1;
            end
            if (state == ST_WRITE && wr_ack) begin
                if (wr_err) begin
                    wr_err_flag <= 1'b1;
                end else begin
                    remain <= remain - CW'(1);
                    rd_ptr <= rd_next;
                    wr_ptr <= wr_next;
                end
            end
        end
    end

    // Bus-facing outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        rd_req  = (state == ST_READ);
        wr_req  = (state == ST_WRITE);
        rd_addr = rd_ptr;
        wr_addr = wr_ptr;
        rd_size = cfg_q.size;
        wr_size = cfg_q.size;
        wr_data = beat_data;
    end
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
    parameter int CH_IDX = 0,
    parameter int NUM_CH = 16,
    parameter int AW     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              rd_req,
    input logic              rd_ack,
    input logic [AW-1:0]     rd_addr,
    input logic              wr_req,
    input logic              wr_ack,
    input logic [AW-1:0]     wr_addr,
    input logic [31:0]       wr_data,
    input logic              busy,
    input logic              done,
    input logic              irq,
    input logic [NUM_CH-1:0] chain_trig,
    input logic              rd_err_flag
);
    assert_no_dual_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));

    assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    assert_wr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

    assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_irq_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);

    assert_chain_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chain_trig) && !chain_trig[CH_IDX]);

    assert_chain_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_trig != '0) |-> done);

    assert_err_nodone_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_err_flag) |-> !done);
endmodule

bind dma_chan_seq dma_chan_seq_chk #(
    .CH_IDX (CH_IDX),
    .NUM_CH (NUM_CH),
    .AW     (AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .rd_req      (rd_req),
    .rd_ack      (rd_ack),
    .rd_addr     (rd_addr),
    .wr_req      (wr_req),
    .wr_ack      (wr_ack),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .busy        (busy),
    .done        (done),
    .irq         (irq),
    .chain_trig  (chain_trig),
    .rd_err_flag (rd_err_flag)
);

// File: tb/tb_dma_chan_seq.sv
module tb_dma_chan_seq;
    localparam int CH_IDX = 2;
    localparam int NUM_CH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, abort = 1'b0;
    logic [1:0]  cfg_size = 2'd2;
    logic        cfg_rd_inc = 1'b0, cfg_rd_rev = 1'b0, cfg_wr_inc = 1'b0, cfg_wr_rev = 1'b0;
    logic [3:0]  cfg_ring_log = 4'd0;
    logic        cfg_ring_on_wr = 1'b0;
    logic [3:0]  cfg_chain_to = 4'd5;
    logic [5:0]  cfg_pace_sel = 6'd63;
    logic        cfg_quiet = 1'b0, cfg_swap = 1'b0;
    logic [31:0] init_rd_addr = '0, init_wr_addr = '0, init_count = '0;
    logic [62:0] dreq = '0;
    logic        rd_req, wr_req;
    logic [31:0] rd_addr, wr_addr, wr_data;
    logic [1:0]  rd_size, wr_size;
    logic        rd_ack = 1'b0, rd_err = 1'b0, wr_ack = 1'b0, wr_err = 1'b0;
    logic [31:0] rd_data = '0;
    logic        busy, done, irq, rd_err_flag, wr_err_flag;
    logic [NUM_CH-1:0] chain_trig;

    int checks = 0, fails = 0, cycles = 0, beats = 0;
    logic stall_rd = 1'b0, inj_rd_err = 1'b0, inj_wr_err = 1'b0;
    logic saw_done = 1'b0, saw_chain = 1'b0;
    logic [31:0] e_rd, e_wr;

    typedef struct packed {
        logic [1:0]  size;
        logic        rinc, rrev, winc, wrev;
        logic [3:0]  ring_log;
        logic        ring_wr, swap;
        logic [7:0]  count;
        logic [31:0] rbase, wbase;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 8'd4, 32'h1000, 32'h2000},
        '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 8'd5, 32'h1003, 32'h3000},
        '{2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0, 1'b0, 1'b1, 8'd4, 32'h1010, 32'h2000},
        '{2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 4'd3, 1'b0, 1'b0, 8'd5, 32'h1000, 32'h4000},
        '{2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 4'd4, 1'b1, 1'b1, 8'd4, 32'h0100, 32'h5008},
        '{2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 8'd3, 32'h7002, 32'h6000}
    };

    dma_chan_seq #(.CH_IDX(CH_IDX), .NUM_CH(NUM_CH)) dut (.*);

    always #5 clk = ~clk;

    task automatic check(input logic ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {~a[7:0], a[7:0] + 8'd1, a[15:8], a[7:0]};
    endfunction

    function automatic logic [31:0] exp_data(input logic [31:0] a, input logic [1:0] sz,
                                             input logic sw);
        logic [31:0] p = pat(a);
        logic [31:0] o = '0;
        int nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        for (int i = 0; i < nb; i++)
            o[i*8 +: 8] = sw ? p[(nb-1-i)*8 +: 8] : p[i*8 +: 8];
        return o;
    endfunction

    function automatic logic [31:0] step(input logic [31:0] a, input logic inc, input logic rev,
                                         input logic [1:0] sz, input logic wrap,
                                         input logic [3:0] lg);
        logic [31:0] s = (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
        logic [31:0] r = rev ? a - s : a + s;
        logic [31:0] m = (32'd1 << lg) - 32'd1;
        if (!inc) return a;
        return wrap ? ((a & ~m) | (r & m)) : r;
    endfunction

    // Memory responder: acknowledges each request and checks it against the model.
    always @(negedge clk) begin
        rd_ack <= 1'b0; wr_ack <= 1'b0; rd_err <= 1'b0; wr_err <= 1'b0;
        if (done) saw_done = 1'b1;
        if (chain_trig != '0) saw_chain = 1'b1;
        if (rd_req && !rd_ack && !stall_rd) begin
            check(rd_addr == e_rd, "R4/R5", "read address", rd_addr, e_rd);
            check(rd_size == cfg_size, "R3", "read size", rd_size, cfg_size);
            rd_data <= pat(rd_addr);
            rd_err  <= inj_rd_err;
            rd_ack  <= 1'b1;
        end
        if (wr_req && !wr_ack) begin
            check(wr_addr == e_wr, "R4/R5", "write address", wr_addr, e_wr);
            check(wr_data == exp_data(e_rd, cfg_size, cfg_swap), "R6", "write data",
                  wr_data, exp_data(e_rd, cfg_size, cfg_swap));
            check(wr_size == cfg_size, "R3", "write size", wr_size, cfg_size);
            e_rd = step(e_rd, cfg_rd_inc, cfg_rd_rev, cfg_size,
                        cfg_ring_log != 0 && !cfg_ring_on_wr, cfg_ring_log);
            e_wr = step(e_wr, cfg_wr_inc, cfg_wr_rev, cfg_size,
                        cfg_ring_log != 0 && cfg_ring_on_wr, cfg_ring_log);
            beats++;
            wr_err <= inj_wr_err;
            wr_ack <= 1'b1;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog R1: actual %0d expected below 100000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic launch();
        e_rd = init_rd_addr; e_wr = init_wr_addr; beats = 0;
        saw_done = 1'b0; saw_chain = 1'b0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(busy == 1'b1, "R1", "busy after start", busy, 1);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({busy, rd_req, wr_req, done, irq} == 5'b0, "R1", "reset outputs",
              {busy, rd_req, wr_req, done, irq}, 0);
        check(chain_trig == '0 && !rd_err_flag && !wr_err_flag, "R11", "reset flags",
              {chain_trig, rd_err_flag, wr_err_flag}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table-driven transfers
        for (int v = 0; v < 6; v++) begin
            cfg_size = VECS[v].size; cfg_rd_inc = VECS[v].rinc; cfg_rd_rev = VECS[v].rrev;
            cfg_wr_inc = VECS[v].winc; cfg_wr_rev = VECS[v].wrev;
            cfg_ring_log = VECS[v].ring_log; cfg_ring_on_wr = VECS[v].ring_wr;
            cfg_swap = VECS[v].swap; cfg_pace_sel = 6'd63; cfg_quiet = 1'b0;
            cfg_chain_to = 4'd5;
            init_count = 32'(VECS[v].count);
            init_rd_addr = VECS[v].rbase; init_wr_addr = VECS[v].wbase;
            launch();
            for (int i = 0; i < 400 && !done; i++) @(negedge clk);
            check(done == 1'b1 && busy == 1'b0, "R9", "done pulse with busy low",
                  {done, busy}, 2'b10);
            check(irq == 1'b1, "R9", "irq with done", irq, 1);
            check(chain_trig == 16'h0020, "R10", "chain trigger", chain_trig, 16'h0020);
            check(beats == int'(VECS[v].count), "R8", "beat count", beats, VECS[v].count);
            @(negedge clk);
            check(done == 1'b0, "R9", "done one cycle", done, 0);
        end

        // R7 pacing and R1 start ignored while busy
        cfg_size = 2'd2; cfg_rd_inc = 1'b1; cfg_rd_rev = 1'b0; cfg_wr_inc = 1'b1;
        cfg_wr_rev = 1'b0; cfg_ring_log = 4'd0; cfg_swap = 1'b0;
        cfg_pace_sel = 6'd7; dreq = '0; dreq[6] = 1'b1;
        init_count = 32'd2; init_rd_addr = 32'h8000; init_wr_addr = 32'h9000;
        launch();
        init_count = 32'd9; init_rd_addr = 32'hA000;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (6) @(negedge clk);
        check(beats == 0 && rd_req == 1'b0 && busy == 1'b1, "R7", "held without dreq[7]",
              {beats[7:0], rd_req, busy}, 10'b1);
        dreq[7] = 1'b1;
        wait_idle();
        check(saw_done == 1'b1, "R7", "completes once paced", saw_done, 1);
        check(beats == 2, "R1", "restart while busy ignored", beats, 2);
        dreq = '0;

        // R9 quiet and R10 chain to self
        cfg_pace_sel = 6'd63; cfg_quiet = 1'b1; cfg_chain_to = 4'(CH_IDX);
        init_count = 32'd1; init_rd_addr = 32'h100; init_wr_addr = 32'h200;
        launch();
        for (int i = 0; i < 50 && !done; i++) @(negedge clk);
        check(done == 1'b1 && irq == 1'b0, "R9", "quiet suppresses irq", {done, irq}, 2'b10);
        check(chain_trig == '0, "R10", "chain to self gives none", chain_trig, 0);

        // R8 zero count
        cfg_quiet = 1'b0; cfg_chain_to = 4'd3; init_count = 32'd0;
        launch();
        wait_idle();
        check(saw_done == 1'b1 && beats == 0, "R8", "zero count completes with no beats",
              {saw_done, beats[7:0]}, 9'h100);
        check(saw_chain == 1'b1, "R10", "zero count chains", saw_chain, 1);

        // R11 read error
        init_count = 32'd3; inj_rd_err = 1'b1;
        launch();
        wait_idle();
        inj_rd_err = 1'b0;
        check(rd_err_flag == 1'b1 && wr_err_flag == 1'b0, "R11", "read error flag",
              {rd_err_flag, wr_err_flag}, 2'b10);
        check(!saw_done && !saw_chain && beats == 0 && !busy, "R11", "read error ends quietly",
              {saw_done, saw_chain, beats[7:0], busy}, 0);

        // R11 write error, then flags cleared by the next start
        inj_wr_err = 1'b1;
        launch();
        wait_idle();
        inj_wr_err = 1'b0;
        check(wr_err_flag == 1'b1 && rd_err_flag == 1'b0, "R11", "write error flag",
              {rd_err_flag, wr_err_flag}, 2'b01);
        check(!saw_done && beats == 1, "R11", "write error stops after one beat",
              {saw_done, beats[7:0]}, 1);
        init_count = 32'd1;
        launch();
        check(!wr_err_flag && !rd_err_flag, "R11", "flags cleared on start",
              {rd_err_flag, wr_err_flag}, 0);
        wait_idle();

        // R12 abort during an outstanding read
        init_count = 32'd6; stall_rd = 1'b1;
        launch();
        for (int i = 0; i < 20 && !rd_req; i++) @(negedge clk);
        abort = 1'b1;
        @(negedge clk) abort = 1'b0;
        repeat (2) @(negedge clk);
        check(busy == 1'b1 && rd_req == 1'b1, "R12", "waits for current request",
              {busy, rd_req}, 2'b11);
        stall_rd = 1'b0;
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && beats == 0, "R12", "abort ends transfer",
              {busy, beats[7:0]}, 0);
        check(!saw_done && !saw_chain, "R12", "no completion after abort",
              {saw_done, saw_chain}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule